// File: doc/BRIEF.md
# Bit Clock and Transmit Frame Sync Generator

This block serves a buffered serial port that drives the bit clock itself. It picks one of four source clocks and divides it down into a bit clock. It also produces the transmit frame sync. Everything runs in one fast system clock domain. Each source clock arrives as a one-cycle tick on `src_tick`, and each tick marks a rising edge of that source. The bit clock leaves the block as a registered level `bclk`. A companion strobe `bclk_edge` marks every rising edge of the bit clock, so downstream shift logic can use it as a clock enable.

Two active-low control bits take the place of resets for the block's two halves. `gen_rst_n` stops the clock divider and `fs_rst_n` stops the periodic frame generator, and each can be held independently of the other. The transmit frame sync comes from one of two sources. One is a periodic generator with a programmable period and pulse width. The other is a one-bit-period pulse issued for every copy of the transmit data register into the shift register. `clk_ok` tells consumers when the bit clock has run long enough after release to be relied on. The asynchronous system reset `rst_n` is released synchronously inside the block.

Top module: `bitclk_fsync_gen`

## Requirements
- R1: While `rst_n` is low, and for two clock cycles after it rises, `bclk`, `bclk_edge`, `fsx` and `clk_ok` are all 0.
- R2: The source index is 2*`pin_sel` + `rate_sel`. Only ticks on `src_tick[index]` advance the bit clock, and ticks on the other three lines have no effect.
- R3: While `gen_rst_n` is 0, `bclk` is 0 from the next clock cycle onward. Copy strobes received in that time are dropped.
- R4: After `gen_rst_n` goes to 1, the first selected tick drives `bclk` to 1 at that clock edge, and `bclk_edge` is 1 in the same cycle.
- R5: For a nonzero `div_val`, one bit period spans `div_val`+1 selected ticks. `bclk` is high for the first ceil((`div_val`+1)/2) ticks and low for the rest. `bclk_edge` is high for one clock cycle at the start of each period. A changed `div_val` takes effect without a restart.
- R6: With `div_val` = 0, the source passes through undivided. `bclk` is 1 in exactly the clock cycles that follow a selected tick, and `bclk_edge` accompanies each one.
- R7: `clk_ok` goes to 1 at the third bit-clock rising edge after `gen_rst_n` is released, which leaves two full bit periods. It returns to 0 when `gen_rst_n` is 0.
- R8: With `fs_mode` = 1 and `fs_rst_n` = 0, `fsx` is 0 from the next cycle, even while the bit clock runs.
- R9: With `fs_mode` = 1, the first frame starts at the first bit edge after both `gen_rst_n` and `fs_rst_n` are 1. Each frame lasts `frame_per`+1 bit periods, and `fsx` is high for the first `frame_wid`+1 of them. `fsx` stays high continuously when `frame_wid` ≥ `frame_per`.
- R10: With `fs_mode` = 0, a `xfer_copy` strobe makes `fsx` high for exactly one bit period, starting at the next bit edge. A strobe that coincides with a bit edge is taken at that edge. Several strobes within one bit period yield a single pulse.
- R11: Unless `fs_mode`, `fs_rst_n` or `gen_rst_n` changed in the cycle before, `fsx` changes only in cycles where `bclk_edge` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick | input | 4 | One-cycle rising-edge ticks of the four candidate source clocks |
| rate_sel | input | 1 | Low bit of the source index |
| pin_sel | input | 1 | High bit of the source index |
| gen_rst_n | input | 1 | Active-low run control of the clock divider |
| fs_rst_n | input | 1 | Active-low run control of the periodic frame generator |
| fs_mode | input | 1 | 1: periodic frame sync, 0: copy-triggered frame sync |
| div_val | input | 8 | Divide value; the bit period is div_val+1 source ticks |
| frame_per | input | 12 | Frame period minus one, in bit periods |
| frame_wid | input | 8 | Frame pulse width minus one, in bit periods |
| xfer_copy | input | 1 | Strobe marking a data-register-to-shift-register copy |
| bclk | output | 1 | Bit clock level |
| bclk_edge | output | 1 | One-cycle strobe at each bit-clock rising edge |
| fsx | output | 1 | Transmit frame sync |
| clk_ok | output | 1 | Bit clock settled after release |

## Verification
In copy-triggered mode, a copy strobe and a bit-clock rising edge can land in the same clock cycle. The block must then emit the pulse at that edge rather than one period later. The bench drives random copy strobes against slow and irregular tick sources, so many strobes hit edge cycles. It also holds the copy line high for many cycles in a row. A reference model that defines the same-cycle case as "taken now" judges every cycle. A second collision is a change of `div_val` or of the source select while the period counter is mid-count. The bench makes these changes mid-run, and the model fixes where the next edge must fall.

// File: rtl/bfg_pkg.sv
package bfg_pkg;

  // Number of candidate source clocks, addressed by two select bits.
  localparam int unsigned BFG_NSRC  = 4;
  localparam int unsigned BFG_SEL_W = 2;

  // Named source slots (index = 2*pin_sel + rate_sel).
  typedef enum logic [BFG_SEL_W-1:0] {
    SRC_SLOT0 = 2'd0,
    SRC_SLOT1 = 2'd1,
    SRC_SLOT2 = 2'd2,
    SRC_SLOT3 = 2'd3
  } bfg_src_e;

endpackage

// File: rtl/bfg_rst_sync.sv
module bfg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/bfg_src_sel.sv
module bfg_src_sel
  import bfg_pkg::*;
#(
  parameter int unsigned NSRC = BFG_NSRC
) (
  input  logic [NSRC-1:0] src_tick,
  input  logic            rate_sel,
  input  logic            pin_sel,
  output logic            sel_tick
);

  localparam int unsigned SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  bfg_src_e           src_idx;
  logic [NSRC-1:0]    hit;

  assign src_idx = bfg_src_e'({pin_sel, rate_sel});

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_hit
      assign hit[g] = src_tick[g] & (SEL_W'(src_idx) == SEL_W'(g));
    end
  endgenerate

  assign sel_tick = |hit;

endmodule

// File: rtl/bfg_clk_div.sv
module bfg_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  output logic             bclk,
  output logic             edge_now,
  output logic             edge_q,
  output logic             ok
);

  localparam int unsigned HW = DIV_W + 1;
  localparam logic [1:0]  OK_CNT = 2'd3;

  logic [DIV_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             on_q, on_d;
  logic             bclk_q, bclk_d;
  logic             edge_d;
  logic [1:0]       okc_q, okc_d;
  logic [HW-1:0]    hi_len;
  logic             pass;
  logic             en_cnt;

  // Length of the high phase: ceil((div+1)/2) ticks.
  assign hi_len  = ({1'b0, div} + HW'(2)) >> 1;
  assign pass    = (div == '0);
  assign cnt_inc = (cnt_q >= div) ? '0 : cnt_q + 1'b1;
  assign en_cnt  = run & tick;

  always_comb begin
    edge_now = en_cnt & (~on_q | (cnt_inc == '0));
  end

  always_comb begin
    cnt_d  = cnt_q;
    on_d   = on_q;
    bclk_d = bclk_q;
    if (!run) begin
      cnt_d  = '0;
      on_d   = 1'b0;
      bclk_d = 1'b0;
    end else if (tick) begin
      on_d   = 1'b1;
      cnt_d  = on_q ? cnt_inc : '0;
      bclk_d = ~on_q | pass | ({1'b0, cnt_inc} < hi_len);
    end else if (pass && on_q) begin
      bclk_d = 1'b0;
    end
  end

  always_comb begin
    edge_d = edge_now;
  end

  always_comb begin
    okc_d = okc_q;
    if (!run) begin
      okc_d = 2'd0;
    end else if (edge_now && (okc_q != OK_CNT)) begin
      okc_d = okc_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q  <= '0;
      on_q   <= 1'b0;
      bclk_q <= 1'b0;
      edge_q <= 1'b0;
      okc_q  <= 2'd0;
    end else begin
      cnt_q  <= cnt_d;
      on_q   <= on_d;
      bclk_q <= bclk_d;
      edge_q <= edge_d;
      okc_q  <= okc_d;
    end
  end

  assign bclk = bclk_q;
  assign ok   = (okc_q == OK_CNT);

endmodule

// File: rtl/bfg_fs_periodic.sv
module bfg_fs_periodic #(
  parameter int unsigned PER_W = 12,
  parameter int unsigned WID_W = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             gen_run,
  input  logic             fs_run,
  input  logic             edge_now,
  input  logic [PER_W-1:0] per,
  input  logic [WID_W-1:0] wid,
  output logic             fs_o
);

  localparam int unsigned CMP_W = (PER_W > WID_W) ? PER_W : WID_W;

  logic [PER_W-1:0] pos_q, pos_d, pos_nx;
  logic             act_q, act_d;
  logic             fs_q, fs_d;
  logic             live;

  assign live   = gen_run & fs_run;
  assign pos_nx = !act_q ? '0 : ((pos_q >= per) ? '0 : pos_q + 1'b1);

  always_comb begin
    pos_d = pos_q;
    act_d = act_q;
    fs_d  = fs_q;
    if (!live) begin
      pos_d = '0;
      act_d = 1'b0;
      fs_d  = 1'b0;
    end else if (edge_now) begin
      act_d = 1'b1;
      pos_d = pos_nx;
      fs_d  = (CMP_W'(pos_nx) <= CMP_W'(wid));
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pos_q <= '0;
      act_q <= 1'b0;
      fs_q  <= 1'b0;
    end else begin
      pos_q <= pos_d;
      act_q <= act_d;
      fs_q  <= fs_d;
    end
  end

  assign fs_o = fs_q;

endmodule

// File: rtl/bfg_fs_copy.sv
module bfg_fs_copy (
  input  logic clk,
  input  logic srst_n,
  input  logic gen_run,
  input  logic edge_now,
  input  logic copy,
  output logic fs_o
);

  logic pend_q, pend_d;
  logic fs_q, fs_d;

  always_comb begin
    pend_d = pend_q;
    fs_d   = fs_q;
    if (!gen_run) begin
      pend_d = 1'b0;
      fs_d   = 1'b0;
    end else if (edge_now) begin
      fs_d   = pend_q | copy;
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q | copy;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      fs_q   <= fs_d;
    end
  end

  assign fs_o = fs_q;

endmodule

// File: rtl/bitclk_fsync_gen.sv
module bitclk_fsync_gen
  import bfg_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PER_W = 12,
  parameter int unsigned WID_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BFG_NSRC-1:0] src_tick,
  input  logic                rate_sel,
  input  logic                pin_sel,
  input  logic                gen_rst_n,
  input  logic                fs_rst_n,
  input  logic                fs_mode,
  input  logic [DIV_W-1:0]    div_val,
  input  logic [PER_W-1:0]    frame_per,
  input  logic [WID_W-1:0]    frame_wid,
  input  logic                xfer_copy,
  output logic                bclk,
  output logic                bclk_edge,
  output logic                fsx,
  output logic                clk_ok
);

  logic srst_n;
  logic sel_tick;
  logic edge_now;
  logic fs_per;
  logic fs_cpy;

  bfg_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  bfg_src_sel #(.NSRC(BFG_NSRC)) u_src_sel (
    .src_tick (src_tick),
    .rate_sel (rate_sel),
    .pin_sel  (pin_sel),
    .sel_tick (sel_tick)
  );

  bfg_clk_div #(.DIV_W(DIV_W)) u_clk_div (
    .clk      (clk),
    .srst_n   (srst_n),
    .run      (gen_rst_n),
    .tick     (sel_tick),
    .div      (div_val),
    .bclk     (bclk),
    .edge_now (edge_now),
    .edge_q   (bclk_edge),
    .ok       (clk_ok)
  );

  bfg_fs_periodic #(.PER_W(PER_W), .WID_W(WID_W)) u_fs_periodic (
    .clk      (clk),
    .srst_n   (srst_n),
    .gen_run  (gen_rst_n),
    .fs_run   (fs_rst_n),
    .edge_now (edge_now),
    .per      (frame_per),
    .wid      (frame_wid),
    .fs_o     (fs_per)
  );

  bfg_fs_copy u_fs_copy (
    .clk      (clk),
    .srst_n   (srst_n),
    .gen_run  (gen_rst_n),
    .edge_now (edge_now),
    .copy     (xfer_copy),
    .fs_o     (fs_cpy)
  );

  assign fsx = fs_mode ? fs_per : fs_cpy;

endmodule

// File: rtl/bfg_chk.sv
module bfg_chk (
  input logic clk,
  input logic rst_n,
  input logic gen_rst_n,
  input logic fs_rst_n,
  input logic fs_mode,
  input logic sel_tick,
  input logic bclk,
  input logic bclk_edge,
  input logic fsx,
  input logic clk_ok
);

  assert_gen_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_rst_n |=> (!bclk && !clk_ok));

  assert_edge_from_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_edge |-> $past(sel_tick));

  assert_edge_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_edge |-> bclk);

  assert_ready_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ok && !$past(clk_ok)) |-> bclk_edge);

  assert_frame_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_mode && !$past(fs_rst_n)) |-> !fsx);

  assert_fs_on_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((fsx != $past(fsx)) && (fs_mode == $past(fs_mode)) &&
     $past(fs_rst_n) && $past(gen_rst_n)) |-> bclk_edge);

endmodule

bind bitclk_fsync_gen bfg_chk u_bfg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gen_rst_n (gen_rst_n),
  .fs_rst_n  (fs_rst_n),
  .fs_mode   (fs_mode),
  .sel_tick  (sel_tick),
  .bclk      (bclk),
  .bclk_edge (bclk_edge),
  .fsx       (fsx),
  .clk_ok    (clk_ok)
);

// File: tb/test_bitclk_fsync_gen.sv
module test_bitclk_fsync_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = 4'd0;
  logic        rate_sel = 1'b0;
  logic        pin_sel = 1'b0;
  logic        gen_rst_n = 1'b0;
  logic        fs_rst_n = 1'b0;
  logic        fs_mode = 1'b0;
  logic [7:0]  div_val = 8'd0;
  logic [11:0] frame_per = 12'd0;
  logic [7:0]  frame_wid = 8'd0;
  logic        xfer_copy = 1'b0;
  logic        bclk, bclk_edge, fsx, clk_ok;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R1";
  string fs_req = "R1";

  // reference model state
  bit s1 = 0, s2 = 0, irst;
  bit m_on = 0, m_frun = 0, m_pend = 0;
  int m_ph = 0, m_fp = 0, m_rises = 0;
  bit e_bclk = 0, e_edge = 0, e_ok = 0, e_fsi = 0, e_fsc = 0;

  bitclk_fsync_gen i_bitclk_fsync_gen (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .rate_sel(rate_sel),
    .pin_sel(pin_sel), .gen_rst_n(gen_rst_n), .fs_rst_n(fs_rst_n),
    .fs_mode(fs_mode), .div_val(div_val), .frame_per(frame_per),
    .frame_wid(frame_wid), .xfer_copy(xfer_copy), .bclk(bclk),
    .bclk_edge(bclk_edge), .fsx(fsx), .clk_ok(clk_ok)
  );

  always #10 clk = ~clk;

  task automatic m_clear();
    m_on = 0; m_ph = 0; m_rises = 0; m_frun = 0; m_fp = 0; m_pend = 0;
    e_bclk = 0; e_edge = 0; e_ok = 0; e_fsi = 0; e_fsc = 0;
  endtask

  task automatic m_advance();
    bit tk;
    int idx;
    idx = pin_sel * 2 + rate_sel;
    tk = src_tick[idx];
    e_edge = 0;
    if (!gen_rst_n) begin
      m_on = 0; m_ph = 0; e_bclk = 0;
    end else if (tk) begin
      if (!m_on) begin
        m_on = 1; m_ph = 0; e_bclk = 1; e_edge = 1;
      end else begin
        m_ph = (m_ph >= int'(div_val)) ? 0 : m_ph + 1;
        e_edge = (m_ph == 0);
        e_bclk = (div_val == 0) ? 1'b1 : (m_ph < (int'(div_val) + 2) / 2);
      end
    end else if (m_on && div_val == 0) begin
      e_bclk = 0;
    end
    if (!gen_rst_n) m_rises = 0;
    else if (e_edge && m_rises < 3) m_rises++;
    e_ok = (m_rises == 3);
    if (!gen_rst_n || !fs_rst_n) begin
      m_frun = 0; m_fp = 0; e_fsi = 0;
    end else if (e_edge) begin
      if (!m_frun) begin m_frun = 1; m_fp = 0; end
      else m_fp = (m_fp >= int'(frame_per)) ? 0 : m_fp + 1;
      e_fsi = (m_fp <= int'(frame_wid));
    end
    if (!gen_rst_n) begin
      m_pend = 0; e_fsc = 0;
    end else if (e_edge) begin
      e_fsc = m_pend | xfer_copy; m_pend = 0;
    end else begin
      m_pend = m_pend | xfer_copy;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; m_clear();
    end else begin
      irst = s2; s2 = s1; s1 = 1;
      if (!irst) m_clear(); else m_advance();
    end
  end

  task automatic chk(input logic act, input bit exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(bclk, e_bclk, cur_req, "bclk");
      chk(bclk_edge, e_edge, cur_req, "bclk_edge");
      chk(clk_ok, e_ok, (cur_req == "R1") ? "R1" : "R7", "clk_ok");
      chk(fsx, fs_mode ? e_fsi : e_fsc, fs_req, "fsx");
    end
  end

  // source clock ticks: slot0 every cycle, slot1 every 2nd, slot2 every 3rd, slot3 irregular
  always @(negedge clk) begin
    #1;
    cyc++;
    src_tick[0] = 1'b1;
    src_tick[1] = (cyc % 2 == 0);
    src_tick[2] = (cyc % 3 == 0);
    src_tick[3] = (cyc % 5 == 0) || (cyc % 5 == 2);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic copies(input int n, input int one_in);
    for (int i = 0; i < n; i++) begin
      xfer_copy = ($urandom % one_in == 0);
      step(1);
    end
    xfer_copy = 0;
  endtask

  initial begin
    // R1: reset state and synchronous release
    step(4);
    rst_n = 1;
    step(4);
    // R4: first tick after release; R5: divide by 4 on slot1
    cur_req = "R4"; rate_sel = 1; div_val = 8'd3; gen_rst_n = 1;
    step(20);
    cur_req = "R5";
    step(60);
    div_val = 8'd2; rate_sel = 0; pin_sel = 1;
    step(60);
    div_val = 8'd4; rate_sel = 1;
    step(60);
    // R6: pass-through
    cur_req = "R6"; div_val = 8'd0;
    step(40);
    pin_sel = 0; rate_sel = 1;
    step(30);
    // R2: walk every source slot mid-count
    cur_req = "R2"; div_val = 8'd1;
    for (int s = 0; s < 4; s++) begin
      pin_sel = s[1]; rate_sel = s[0];
      step(30);
    end
    // R3: divider held; copies must be dropped
    cur_req = "R3"; fs_req = "R3";
    gen_rst_n = 0;
    copies(20, 2);
    step(5);
    // R7: ready after two full periods
    cur_req = "R7"; div_val = 8'd3; pin_sel = 1; rate_sel = 0;
    gen_rst_n = 1;
    step(60);
    // R8: periodic generator held while clock runs
    cur_req = "R5"; fs_req = "R8"; fs_mode = 1; fs_rst_n = 0;
    div_val = 8'd1; pin_sel = 0; rate_sel = 0;
    step(30);
    // R9: periodic frames
    fs_req = "R9"; frame_per = 12'd5; frame_wid = 8'd1; fs_rst_n = 1;
    step(100);
    frame_per = 12'd3; frame_wid = 8'd5;
    step(40);
    frame_per = 12'd0; frame_wid = 8'd0;
    step(20);
    frame_per = 12'd7; frame_wid = 8'd2; div_val = 8'd2; pin_sel = 1; rate_sel = 1;
    step(120);
    fs_req = "R8"; fs_rst_n = 0;
    step(20);
    fs_req = "R9"; fs_rst_n = 1;
    step(60);
    // R10: copy-triggered pulses, incl. strobes on edge cycles and held strobes
    fs_req = "R10"; fs_mode = 0; div_val = 8'd3; pin_sel = 0; rate_sel = 1;
    copies(300, 7);
    xfer_copy = 1;
    step(20);
    xfer_copy = 0;
    step(20);
    div_val = 8'd0; pin_sel = 1; rate_sel = 1;
    copies(100, 3);
    // R11: alignment with mode toggles and irregular source
    fs_req = "R11"; div_val = 8'd2; fs_rst_n = 1;
    for (int k = 0; k < 6; k++) begin
      fs_mode = ~fs_mode;
      copies(40, 5);
    end
    // R1: reset asserted mid-run
    cur_req = "R1"; fs_req = "R1";
    rst_n = 0;
    step(4);
    rst_n = 1;
    step(2);
    cur_req = "R4"; fs_req = "R11";
    step(40);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule